// File: doc/BRIEF.md
# Persistence-Filtered Command Code Receiver

This block sits between a time-division system bus and four line channels. On every frame each channel delivers a 4-bit command code. The block passes a new code on to the channel logic only after that code has arrived unchanged in enough consecutive frames. A single noisy frame therefore never reaches the line state logic, and software has to hold a code for a known time before the channel reacts. The required run length is not fixed. The three unconditional commands, and any code arriving while the channel reports that it is in its reset or test state, need a long window of 20 frames (2.5 ms at 8 kHz). Other codes on a channel in a normal state need a short window of 4 frames (0.5 ms).

Each channel runs a small state machine with two states. In `ST_STABLE` the last received code matches the accepted code. In `ST_TRACK` a different candidate code is being counted. The transitions are:
- *diverge*: STABLE to TRACK, when a frame differs from the accepted code.
- *restart*: TRACK to TRACK with the count reset to 1, when a frame differs from the candidate.
- *advance*: TRACK to TRACK with the count incremented.
- *fall back*: TRACK to STABLE with no output, when a frame repeats the accepted code.
- *accept*: TRACK to STABLE with the code taken over and a pulse issued, when the count reaches the window.

A second machine drives the indication code sent back to the system. It has two states. `IND_HWRST` sends 1111 on every channel while hardware reset is low. `IND_DEAC` sends 0001 from the first clock edge after reset is released (transition *release*).

Top module: `cmd_persist_rx`

## Requirements
- R1: The accepted code of a channel changes only at a clock edge where `frame_stb` is high. Received codes presented while `frame_stb` is low have no effect.
- R2: An unconditional command (0000 reset, 0010 send-single-pulses, 0011 data-through) is accepted only after it has arrived in 20 consecutive frames. Four such frames are not enough.
- R3: On a channel whose `in_rst_test` bit is 0, any other code is accepted on its 4th consecutive frame.
- R4: While a channel's `in_rst_test` bit is 1, every code needs 20 consecutive frames before it is accepted.
- R5: A frame whose code differs from the candidate makes that frame's code the new candidate, with a count of one.
- R6: Acceptance raises that channel's bit of `chg_pulse` for exactly one cycle: the cycle after the accepting frame edge. The new code appears on `acc_code` in that same cycle.
- R7: The four channels are filtered independently. Channel n uses bits [4n+3:4n] of the code buses and bit n of the flag and pulse vectors.
- R8: While `rst_n` is low, every accepted code reads 0000, every pulse is 0, and any partial count is discarded.
- R9: While `rst_n` is low, `ind_code` reads 1111 on every channel. From the first clock edge after release it reads 0001 on every channel.
- R10: A frame that repeats the accepted code while a candidate is being counted drops the candidate without a pulse. A later run of the candidate counts from one again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous assertion |
| frame_stb | input | 1 | One-cycle strobe marking a frame's codes as valid |
| rx_code | input | 16 | Received codes, channel n in bits [4n+3:4n] |
| in_rst_test | input | 4 | Per-channel flag: channel is in its reset or test state |
| acc_code | output | 16 | Accepted codes, channel n in bits [4n+3:4n] |
| chg_pulse | output | 4 | Per-channel one-cycle pulse when a new code is accepted |
| ind_code | output | 16 | Outgoing indication code, channel n in bits [4n+3:4n] |

## Verification
Two kinds of fault would show at the ports in a recognisable way.

A persistence counter that is held, misloaded or compared against the wrong window moves the acceptance pulse away from its frame. The pulse would appear on the 3rd or 5th frame instead of the 4th, or on the 4th frame for an unconditional code. The frame-exact vector table exposes this on the very frame where the pulse should or should not occur.

A candidate register that is not reloaded on a differing frame, or not dropped on a frame that repeats the accepted code, causes a pulse too early after an interrupted run. Likewise, a count that survives hardware reset yields acceptance on the first frame after release. Each of these is visible within one frame of the disturbance.

// File: rtl/cmd_persist_pkg.sv
package cmd_persist_pkg;

    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] CMD_RESET = 4'b0000;
    localparam logic [CODE_W-1:0] CMD_SSP   = 4'b0010;
    localparam logic [CODE_W-1:0] CMD_THRU  = 4'b0011;

    localparam logic [CODE_W-1:0] IND_RST_CODE  = 4'b1111;
    localparam logic [CODE_W-1:0] IND_DEAC_CODE = 4'b0001;

    typedef enum logic {
        ST_STABLE = 1'b0,
        ST_TRACK  = 1'b1
    } filt_state_t;

    typedef enum logic {
        IND_HWRST = 1'b0,
        IND_DEAC  = 1'b1
    } ind_state_t;

    function automatic logic is_uncond(input logic [CODE_W-1:0] code);
        return (code == CMD_RESET) || (code == CMD_SSP) || (code == CMD_THRU);
    endfunction

endpackage

// File: rtl/cmd_persist_chan.sv
module cmd_persist_chan
    import cmd_persist_pkg::*;
#(
    parameter int LONG_N  = 20,
    parameter int SHORT_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic [CODE_W-1:0] rx_code,
    input  logic              hold_long,
    output logic [CODE_W-1:0] acc_code,
    output logic              chg_pulse
);

    localparam int CNT_W = $clog2(LONG_N + 1);

    filt_state_t       state_q, state_d;
    logic [CODE_W-1:0] cand_q, cand_d;
    logic [CODE_W-1:0] acc_q, acc_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              pls_q, pls_d;
    logic [CNT_W-1:0]  need;

    assign need = (is_uncond(rx_code) || hold_long) ? CNT_W'(LONG_N) : CNT_W'(SHORT_N);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STABLE;
            cand_q  <= '0;
            acc_q   <= '0;
            cnt_q   <= '0;
            pls_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cand_q  <= cand_d;
            acc_q   <= acc_d;
            cnt_q   <= cnt_d;
            pls_q   <= pls_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cand_d  = cand_q;
        acc_d   = acc_q;
        cnt_d   = cnt_q;
        pls_d   = 1'b0;
        if (frame_stb) begin
            unique case (state_q)
                ST_STABLE: begin
                    if (rx_code != acc_q) begin
                        state_d = ST_TRACK;
                        cand_d  = rx_code;
                        cnt_d   = CNT_W'(1);
                    end
                end
                ST_TRACK: begin
                    if (rx_code == acc_q) begin
                        state_d = ST_STABLE;
                        cand_d  = acc_q;
                        cnt_d   = '0;
                    end else if (rx_code != cand_q) begin
                        cand_d = rx_code;
                        cnt_d  = CNT_W'(1);
                    end else if (cnt_q + CNT_W'(1) >= need) begin
                        state_d = ST_STABLE;
                        acc_d   = cand_q;
                        cnt_d   = '0;
                        pls_d   = 1'b1;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                default: state_d = ST_STABLE;
            endcase
        end
    end

    assign acc_code  = acc_q;
    assign chg_pulse = pls_q;

    p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chg_pulse |=> !chg_pulse);

    p_pulse_moves_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chg_pulse |-> !$stable(acc_code));

    p_acc_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_pulse |-> $stable(acc_code));

    p_pulse_on_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        chg_pulse |-> $past(frame_stb));

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(LONG_N));

    p_restart_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && state_q == ST_TRACK && rx_code != cand_q && rx_code != acc_q)
        |=> (cnt_q == CNT_W'(1)));

    p_fallback_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && state_q == ST_TRACK && rx_code == acc_q)
        |=> (state_q == ST_STABLE && !chg_pulse));

endmodule

// File: rtl/cmd_ind_gen.sv
module cmd_ind_gen
    import cmd_persist_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output logic [NCH*CODE_W-1:0] ind_code
);

    ind_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IND_HWRST;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            IND_HWRST: state_d = IND_DEAC;
            IND_DEAC:  state_d = IND_DEAC;
            default:   state_d = IND_HWRST;
        endcase
    end

    always_comb begin
        unique case (state_q)
            IND_HWRST: ind_code = {NCH{IND_RST_CODE}};
            IND_DEAC:  ind_code = {NCH{IND_DEAC_CODE}};
            default:   ind_code = {NCH{IND_RST_CODE}};
        endcase
    end

    p_deac_after_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ind_code == {NCH{IND_DEAC_CODE}}));

endmodule

// File: rtl/cmd_persist_rx.sv
module cmd_persist_rx
    import cmd_persist_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int LONG_N  = 20,
    parameter int SHORT_N = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_stb,
    input  logic [NCH*CODE_W-1:0] rx_code,
    input  logic [NCH-1:0]        in_rst_test,
    output logic [NCH*CODE_W-1:0] acc_code,
    output logic [NCH-1:0]        chg_pulse,
    output logic [NCH*CODE_W-1:0] ind_code
);

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        cmd_persist_chan #(
            .LONG_N  (LONG_N),
            .SHORT_N (SHORT_N)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .frame_stb (frame_stb),
            .rx_code   (rx_code[g*CODE_W +: CODE_W]),
            .hold_long (in_rst_test[g]),
            .acc_code  (acc_code[g*CODE_W +: CODE_W]),
            .chg_pulse (chg_pulse[g])
        );
    end

    cmd_ind_gen #(.NCH(NCH)) u_ind (
        .clk      (clk),
        .rst_n    (rst_n),
        .ind_code (ind_code)
    );

    p_no_pulse_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> (chg_pulse == '0));

endmodule

// File: tb/sim_cmd_persist_rx.sv
module sim_cmd_persist_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_stb = 1'b0;
    logic [15:0] rx_code = 16'h0000;
    logic [3:0]  in_rst_test = 4'h0;
    logic [15:0] acc_code;
    logic [3:0]  chg_pulse;
    logic [15:0] ind_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cmd_persist_rx u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_stb   (frame_stb),
        .rx_code     (rx_code),
        .in_rst_test (in_rst_test),
        .acc_code    (acc_code),
        .chg_pulse   (chg_pulse),
        .ind_code    (ind_code)
    );

    // {rx_code, in_rst_test, expected acc_code, expected chg_pulse}
    // ch0: 9 normal (4 frames); ch1: 2 unconditional (20); ch2: 7 with flag (20);
    // ch3: 6,6,8,6... restart then 4 frames; ch0 later 0 only 4 frames (needs 20)
    localparam logic [39:0] VEC [24] = '{
        40'h6729_4_0000_0, 40'h6729_4_0000_0, 40'h8729_4_0000_0, 40'h6729_4_0009_1,
        40'h6729_4_0009_0, 40'h6729_4_0009_0, 40'h6729_4_6009_8, 40'h6729_4_6009_0,
        40'h6729_4_6009_0, 40'h6729_4_6009_0, 40'h6729_4_6009_0, 40'h6729_4_6009_0,
        40'h6729_4_6009_0, 40'h6729_4_6009_0, 40'h6729_4_6009_0, 40'h6729_4_6009_0,
        40'h6729_4_6009_0, 40'h6729_4_6009_0, 40'h6729_4_6009_0, 40'h6729_4_6729_6,
        40'h6720_4_6729_0, 40'h6720_4_6729_0, 40'h6720_4_6729_0, 40'h6720_4_6729_0
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic frame(input logic [15:0] rx, input logic [3:0] fl);
        @(negedge clk);
        rx_code = rx;
        in_rst_test = fl;
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // reset state
        repeat (3) @(negedge clk);
        chk("R9 ind during reset", ind_code, 16'hFFFF);
        chk("R8 acc during reset", acc_code, 16'h0000);
        chk("R8 pulse during reset", {12'h0, chg_pulse}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 ind after release", ind_code, 16'h1111);

        // vector table: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < 24; i++) begin
            frame(VEC[i][39:24], VEC[i][23:20]);
            chk($sformatf("R2/R3/R4/R5/R7 acc frame %0d", i + 1), acc_code, VEC[i][19:4]);
            chk($sformatf("R6 pulse frame %0d", i + 1), {12'h0, chg_pulse}, {12'h0, VEC[i][3:0]});
        end

        // R1: codes without strobe are ignored
        @(negedge clk);
        rx_code = 16'hABCD;
        in_rst_test = 4'h0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (chg_pulse != 4'h0) chk("R1 no pulse without strobe", {12'h0, chg_pulse}, 16'h0);
        end
        chk("R1 acc kept without strobe", acc_code, 16'h6729);

        // R8: partial count discarded by hardware reset
        for (int k = 0; k < 3; k++) frame(16'h672C, 4'h0);
        chk("R8 no accept after 3", acc_code, 16'h6729);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 acc cleared", acc_code, 16'h0000);
        chk("R9 ind back to reset code", ind_code, 16'hFFFF);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 ind deac again", ind_code, 16'h1111);
        frame(16'h000C, 4'h0);
        chk("R8 count restarted frame 1", acc_code, 16'h0000);
        frame(16'h000C, 4'h0);
        frame(16'h000C, 4'h0);
        chk("R8 count restarted frame 3", acc_code, 16'h0000);
        frame(16'h000C, 4'h0);
        chk("R3 accept on frame 4", acc_code, 16'h000C);
        chk("R6 pulse on accept", {12'h0, chg_pulse}, 16'h0001);
        @(negedge clk);
        chk("R6 pulse one cycle", {12'h0, chg_pulse}, 16'h0000);

        // R10: return to accepted code drops candidate
        frame(16'h0005, 4'h0);
        frame(16'h0005, 4'h0);
        frame(16'h000C, 4'h0);
        chk("R10 no pulse on fall back", {12'h0, chg_pulse}, 16'h0000);
        frame(16'h0005, 4'h0);
        frame(16'h0005, 4'h0);
        frame(16'h0005, 4'h0);
        chk("R10 candidate counted from one", acc_code, 16'h000C);
        frame(16'h0005, 4'h0);
        chk("R10 accept after fresh run", acc_code, 16'h0005);

        // R4: flag raises window for conditional code on ch1
        for (int k = 0; k < 19; k++) frame(16'h0095, 4'h2);
        chk("R4 not accepted after 19", acc_code, 16'h0005);
        frame(16'h0095, 4'h2);
        chk("R4 accepted on 20", acc_code, 16'h0095);
        chk("R4 pulse ch1", {12'h0, chg_pulse}, 16'h0002);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule